// File: doc/BRIEF.md
# Autoranging Gain Controller with Shift Recovery

This block is the digital side of an automatic gain loop wrapped around a 10-bit unipolar converter. The analog front end places the signal on a half-scale bias and amplifies it through a programmable gain stage. That stage only offers gains that are powers of two. Each converted code enters the block. The block removes the bias and undoes the present gain with an arithmetic shift, so no multiplier or divider is needed. It then adds back the correction value last sent to the external DAC, which rebuilds the original signal.

A running mean over the latest 32 recovered values feeds the 5-bit correction code. A separate path tracks the largest bias-free amplitude over a fixed window of samples and smooths it with a first-order shift filter. It then decides, with a three-way on/off rule, whether to raise the gain, lower it, or leave it alone. Both decision thresholds are inputs, so software or a neighbouring block can set the hysteresis band.

Top module: `agc_shift_ctrl`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the block clears its outputs: `gain_exp` = 0, `gain_changed` = 0, `dac_code` = 0, `recon_valid` = 0 and `recon_sample` = 0. It also clears the averaging history, the window state and the filtered peak.
- R2: For an accepted sample, the bias-free value is c = `sample_code` − 512. The recovered value is c shifted right arithmetically by g when the gain exponent g ≥ 0, and c shifted left by −g when g < 0. Here g is the `gain_exp` in force at that edge.
- R3: One cycle after an accepted sample, `recon_valid` is 1 and `recon_sample` equals the recovered value plus 32 × `dac_code`. The `dac_code` term is the signed value held before that sample.
- R4: The history holds the last 32 recovered values and starts at zero. After each accepted sample, its sum is shifted right arithmetically by 5, which rounds toward minus infinity. The result is clamped to the signed range −512..511. `dac_code` becomes bits 9..5 of that 10-bit two's complement value and is read as a signed 5-bit number.
- R5: Samples are grouped into windows of 16 accepted samples. For each window the block keeps the largest |c|.
- R6: At the last sample of a window, the filtered peak f becomes f + ((p − f) >>> 3). Here p is that window's largest |c|, and the shift rounds toward minus infinity.
- R7: Only at a window end, the new f is compared with the thresholds. If f < `thr_low`, the block raises the gain exponent by one. Otherwise, if f > `thr_high`, it lowers the exponent by one. Otherwise the gain holds. The raise test has priority over the lower test.
- R8: The gain exponent never leaves the range −2..5. A step that would cross a limit becomes a hold.
- R9: When the exponent changes, `gain_changed` is 1 in the same cycle in which the new `gain_exp` first appears. It is 0 in every other cycle, and the exponent changes by exactly one.
- R10: A cycle with `sample_valid` low advances nothing. `recon_valid` and `gain_changed` are 0 in the following cycle. `recon_sample`, `dac_code` and `gain_exp` keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sample_valid | input | 1 | A converter code is present this cycle |
| sample_code | input | 10 | Unsigned converter code, biased at half scale |
| thr_low | input | 10 | Filtered-peak level below which gain rises |
| thr_high | input | 10 | Filtered-peak level above which gain falls |
| gain_exp | output | 4 | Signed power-of-two exponent for the external gain stage |
| gain_changed | output | 1 | One-cycle pulse when `gain_exp` moves |
| dac_code | output | 5 | Signed correction code for the external DAC |
| recon_valid | output | 1 | `recon_sample` was updated this cycle |
| recon_sample | output | 14 | Signed rebuilt input sample |

## Verification
The checker watches four things on every cycle. The exponent must stay inside its legal range. It must move only by single steps, and only together with the change pulse. The change pulse and the output strobe may follow only an accepted sample. When no sample arrives, the correction code must stay put. The exact arithmetic cannot be checked that way: the shift recovery, the floor-rounded running mean and its clamp, the filtered peak, and the choice between raising, lowering and holding. Those are shown only by the bench. It runs closed-loop and open-loop amplitude scenarios, gapped sample streams and altered thresholds against a behavioural model.

// File: rtl/agc_pkg.sv
// Shared definitions for the autoranging gain controller.
// Assumes: nothing beyond IEEE 1800-2017 types.
package agc_pkg;

    // Decision of the on/off controller at a window boundary
    typedef enum logic [1:0] {
        GC_HOLD  = 2'd0,
        GC_RAISE = 2'd1,
        GC_LOWER = 2'd2
    } gain_cmd_e;

endpackage

// File: rtl/agc_shift_recover.sv
// Removes the half-scale bias from a converter code and undoes the
// power-of-two gain with an arithmetic shift. Also reports |bias-free code|.
// Assumes: gain_exp lies in the legal clamp range and REC_W covers the
// widest left shift (ADC_W + 1 - GAIN_MIN bits).
module agc_shift_recover #(
    parameter int ADC_W = 10,
    parameter int GW    = 4,
    parameter int REC_W = 13
) (
    input  logic [ADC_W-1:0]        sample_code,
    input  logic signed [GW-1:0]    gain_exp,
    output logic [ADC_W-1:0]        amplitude,
    output logic signed [REC_W-1:0] recovered
);

    localparam logic signed [ADC_W:0] MID = (ADC_W+1)'(1 << (ADC_W-1));

    logic signed [ADC_W:0]    centered;
    logic signed [REC_W-1:0]  widened;
    logic signed [GW-1:0]     neg_gain;

    // Bias removal and magnitude of the bias-free value
    always_comb begin
        centered  = $signed({1'b0, sample_code}) - MID;
        amplitude = centered[ADC_W] ? ADC_W'(-centered) : ADC_W'(centered);
    end

    // Shift right for gain above unity, left for attenuation
    always_comb begin
        widened  = {{(REC_W-ADC_W-1){centered[ADC_W]}}, centered};
        neg_gain = -gain_exp;
        if (gain_exp[GW-1] == 1'b0) begin
            recovered = widened >>> $unsigned(gain_exp);
        end else begin
            recovered = widened <<< $unsigned(neg_gain);
        end
    end

endmodule

// File: rtl/agc_moving_avg.sv
// Running mean of the last 2**LEN_LOG2 recovered samples; emits the top
// DAC_W bits of the mean, clamped to an AVG_W-bit signed range.
// Assumes: en is high for exactly one cycle per accepted sample.
module agc_moving_avg #(
    parameter int REC_W    = 13,
    parameter int LEN_LOG2 = 5,
    parameter int AVG_W    = 10,
    parameter int DAC_W    = 5
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    en,
    input  logic signed [REC_W-1:0] sample,
    output logic [DAC_W-1:0]        dac_code
);

    localparam int LEN   = 1 << LEN_LOG2;
    localparam int SUM_W = REC_W + LEN_LOG2;
    localparam logic signed [SUM_W-1:0] AVG_HI = SUM_W'((1 <<< (AVG_W-1)) - 1);
    localparam logic signed [SUM_W-1:0] AVG_LO = SUM_W'(-(1 <<< (AVG_W-1)));

    logic signed [REC_W-1:0] hist [LEN];
    logic signed [SUM_W-1:0] sum_q;
    logic signed [SUM_W-1:0] sum_next;
    logic signed [SUM_W-1:0] mean_raw;
    logic signed [AVG_W-1:0] mean_clamped;

    // Next sum: add the newcomer, drop the oldest entry
    always_comb begin
        sum_next = sum_q + SUM_W'(sample) - SUM_W'(hist[LEN-1]);
        mean_raw = sum_next >>> LEN_LOG2;
        if (mean_raw > AVG_HI) begin
            mean_clamped = AVG_HI[AVG_W-1:0];
        end else if (mean_raw < AVG_LO) begin
            mean_clamped = AVG_LO[AVG_W-1:0];
        end else begin
            mean_clamped = mean_raw[AVG_W-1:0];
        end
    end

    // History shift register, running sum and correction code
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < LEN; i++) begin
                hist[i] <= '0;
            end
            sum_q    <= '0;
            dac_code <= '0;
        end else if (en) begin
            hist[0] <= sample;
            for (int i = 1; i < LEN; i++) begin
                hist[i] <= hist[i-1];
            end
            sum_q    <= sum_next;
            dac_code <= mean_clamped[AVG_W-1 -: DAC_W];
        end
    end

endmodule

// File: rtl/agc_peak_ctrl.sv
// Window peak detector, first-order shift low-pass filter and three-way
// on/off gain controller with a programmable dead zone.
// Assumes: en is high once per accepted sample; gain steps only at a
// window boundary, at most one step each time.
module agc_peak_ctrl
    import agc_pkg::*;
#(
    parameter int ADC_W     = 10,
    parameter int WIN_LOG2  = 4,
    parameter int LPF_SHIFT = 3,
    parameter int GAIN_MIN  = -2,
    parameter int GAIN_MAX  = 5,
    parameter int GW        = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en,
    input  logic [ADC_W-1:0]     amplitude,
    input  logic [ADC_W-1:0]     thr_low,
    input  logic [ADC_W-1:0]     thr_high,
    output logic signed [GW-1:0] gain_exp,
    output logic                 gain_changed
);

    localparam logic [WIN_LOG2-1:0] CNT_LAST = WIN_LOG2'((1 << WIN_LOG2) - 1);
    localparam logic signed [GW-1:0] G_HI = GW'(GAIN_MAX);
    localparam logic signed [GW-1:0] G_LO = GW'(GAIN_MIN);

    logic [WIN_LOG2-1:0]   cnt_q;
    logic [ADC_W-1:0]      win_max_q;
    logic [ADC_W-1:0]      lpf_q;
    logic [ADC_W-1:0]      peak_now;
    logic [ADC_W-1:0]      lpf_next;
    logic signed [ADC_W:0] gap;
    logic signed [ADC_W:0] lpf_sum;
    logic                  win_last;
    gain_cmd_e             cmd;

    // Peak including the current sample, and filter update toward it
    always_comb begin
        peak_now = (amplitude > win_max_q) ? amplitude : win_max_q;
        win_last = (cnt_q == CNT_LAST);
        gap      = $signed({1'b0, peak_now}) - $signed({1'b0, lpf_q});
        lpf_sum  = $signed({1'b0, lpf_q}) + (gap >>> LPF_SHIFT);
        lpf_next = lpf_sum[ADC_W-1:0];
    end

    // On/off decision with dead zone and range clamp; raise has priority
    always_comb begin
        cmd = GC_HOLD;
        if (lpf_next < thr_low) begin
            if (gain_exp < G_HI) begin
                cmd = GC_RAISE;
            end
        end else if (lpf_next > thr_high) begin
            if (gain_exp > G_LO) begin
                cmd = GC_LOWER;
            end
        end
    end

    // Window counter, peak register, filter state and gain register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q        <= '0;
            win_max_q    <= '0;
            lpf_q        <= '0;
            gain_exp     <= '0;
            gain_changed <= 1'b0;
        end else begin
            gain_changed <= 1'b0;
            if (en) begin
                if (win_last) begin
                    cnt_q     <= '0;
                    win_max_q <= '0;
                    lpf_q     <= lpf_next;
                    case (cmd)
                        GC_RAISE: begin
                            gain_exp     <= gain_exp + GW'(1);
                            gain_changed <= 1'b1;
                        end
                        GC_LOWER: begin
                            gain_exp     <= gain_exp - GW'(1);
                            gain_changed <= 1'b1;
                        end
                        default: begin
                            gain_exp <= gain_exp;
                        end
                    endcase
                end else begin
                    cnt_q     <= cnt_q + WIN_LOG2'(1);
                    win_max_q <= peak_now;
                end
            end
        end
    end

endmodule

// File: rtl/agc_shift_ctrl.sv
// Top of the autoranging gain controller: shift recovery, correction
// add-back, running-mean DAC code and peak-driven gain control.
// Assumes: one converter code per asserted sample_valid; the external gain
// stage applies gain_exp before the next code is converted.
module agc_shift_ctrl #(
    parameter int ADC_W     = 10,
    parameter int AVG_LOG2  = 5,
    parameter int AVG_W     = 10,
    parameter int DAC_W     = 5,
    parameter int WIN_LOG2  = 4,
    parameter int LPF_SHIFT = 3,
    parameter int GAIN_MIN  = -2,
    parameter int GAIN_MAX  = 5,
    parameter int GW        = 4
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              sample_valid,
    input  logic [ADC_W-1:0]                  sample_code,
    input  logic [ADC_W-1:0]                  thr_low,
    input  logic [ADC_W-1:0]                  thr_high,
    output logic signed [GW-1:0]              gain_exp,
    output logic                              gain_changed,
    output logic [DAC_W-1:0]                  dac_code,
    output logic                              recon_valid,
    output logic signed [ADC_W+1-GAIN_MIN:0]  recon_sample
);

    localparam int REC_W = ADC_W + 1 - GAIN_MIN;
    localparam int OUT_W = REC_W + 1;

    logic signed [REC_W-1:0] recovered;
    logic [ADC_W-1:0]        amplitude;
    logic signed [AVG_W-1:0] correction;

    agc_shift_recover #(
        .ADC_W (ADC_W),
        .GW    (GW),
        .REC_W (REC_W)
    ) u_recover (
        .sample_code (sample_code),
        .gain_exp    (gain_exp),
        .amplitude   (amplitude),
        .recovered   (recovered)
    );

    agc_moving_avg #(
        .REC_W    (REC_W),
        .LEN_LOG2 (AVG_LOG2),
        .AVG_W    (AVG_W),
        .DAC_W    (DAC_W)
    ) u_avg (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (sample_valid),
        .sample   (recovered),
        .dac_code (dac_code)
    );

    agc_peak_ctrl #(
        .ADC_W     (ADC_W),
        .WIN_LOG2  (WIN_LOG2),
        .LPF_SHIFT (LPF_SHIFT),
        .GAIN_MIN  (GAIN_MIN),
        .GAIN_MAX  (GAIN_MAX),
        .GW        (GW)
    ) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .en           (sample_valid),
        .amplitude    (amplitude),
        .thr_low      (thr_low),
        .thr_high     (thr_high),
        .gain_exp     (gain_exp),
        .gain_changed (gain_changed)
    );

    // Held DAC code scaled back to sample units
    always_comb begin
        correction = {dac_code, {(AVG_W-DAC_W){1'b0}}};
    end

    // Rebuilt sample register and its strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            recon_sample <= '0;
            recon_valid  <= 1'b0;
        end else begin
            recon_valid <= sample_valid;
            if (sample_valid) begin
                recon_sample <= OUT_W'(recovered) + OUT_W'(correction);
            end
        end
    end

endmodule

// File: rtl/agc_shift_ctrl_chk.sv
// Port-level temporal checks for the autoranging gain controller.
// Assumes: bound to agc_shift_ctrl with matching parameters.
module agc_shift_ctrl_chk #(
    parameter int GAIN_MIN = -2,
    parameter int GAIN_MAX = 5,
    parameter int GW       = 4,
    parameter int DAC_W    = 5
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 sample_valid,
    input logic signed [GW-1:0] gain_exp,
    input logic                 gain_changed,
    input logic [DAC_W-1:0]     dac_code,
    input logic                 recon_valid
);

    // R8: exponent inside legal range
    a_r8_gain_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(gain_exp) >= GAIN_MIN) && (int'(gain_exp) <= GAIN_MAX));

    // R9: a pulse marks a single-step move
    a_r9_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        gain_changed |-> ((int'(gain_exp) - int'($past(gain_exp)) == 1) ||
                          (int'(gain_exp) - int'($past(gain_exp)) == -1)));

    // R9: without a pulse the exponent does not move
    a_r9_no_silent_move: assert property (@(posedge clk) disable iff (!rst_n)
        !gain_changed |-> $stable(gain_exp));

    // R3: strobe follows an accepted sample by one cycle
    a_r3_strobe_follows: assert property (@(posedge clk) disable iff (!rst_n)
        recon_valid == $past(sample_valid && rst_n));

    // R10: idle cycle leaves the correction code and pulse quiet
    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(sample_valid) |-> ($stable(dac_code) && !gain_changed));

    // R9: a gain pulse only follows an accepted sample
    a_r9_pulse_after_sample: assert property (@(posedge clk) disable iff (!rst_n)
        gain_changed |-> $past(sample_valid));

endmodule

bind agc_shift_ctrl agc_shift_ctrl_chk #(
    .GAIN_MIN (GAIN_MIN),
    .GAIN_MAX (GAIN_MAX),
    .GW       (GW),
    .DAC_W    (DAC_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .sample_valid (sample_valid),
    .gain_exp     (gain_exp),
    .gain_changed (gain_changed),
    .dac_code     (dac_code),
    .recon_valid  (recon_valid)
);

// File: tb/agc_shift_ctrl_test.sv
// Self-checking bench: behavioural reference model updated at each rising
// edge, compared with every output at each falling edge.
module agc_shift_ctrl_test;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              sample_valid = 1'b0;
    logic [9:0]        sample_code = 10'd512;
    logic [9:0]        thr_low = 10'd100;
    logic [9:0]        thr_high = 10'd400;
    logic signed [3:0] gain_exp;
    logic              gain_changed;
    logic [4:0]        dac_code;
    logic              recon_valid;
    logic signed [13:0] recon_sample;

    int n_checks = 0;
    int n_fails  = 0;
    int cycles   = 0;
    bit done     = 1'b0;

    // reference model state
    int m_g = 0, m_dac = 0, m_sum = 0, m_cnt = 0, m_wmax = 0, m_lpf = 0;
    int m_rsamp = 0;
    bit m_rvalid = 0, m_chg = 0;
    int m_hist[$];

    always #5 clk = ~clk;

    agc_shift_ctrl uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .sample_valid (sample_valid),
        .sample_code  (sample_code),
        .thr_low      (thr_low),
        .thr_high     (thr_high),
        .gain_exp     (gain_exp),
        .gain_changed (gain_changed),
        .dac_code     (dac_code),
        .recon_valid  (recon_valid),
        .recon_sample (recon_sample)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cycles);
        end
    endtask

    task automatic model_reset();
        m_g = 0; m_dac = 0; m_sum = 0; m_cnt = 0; m_wmax = 0; m_lpf = 0;
        m_rsamp = 0; m_rvalid = 0; m_chg = 0;
        m_hist.delete();
        for (int i = 0; i < 32; i++) m_hist.push_back(0);
    endtask

    // Reference model, written from the requirements
    always @(posedge clk) begin
        if (!rst_n) begin
            model_reset();
        end else if (sample_valid) begin
            int c, rec, a, ab, wm;
            c   = int'(sample_code) - 512;
            rec = (m_g >= 0) ? (c >>> m_g) : (c <<< (-m_g));   // R2
            m_rsamp  = rec + m_dac * 32;                       // R3
            m_rvalid = 1;
            m_hist.push_front(rec);                            // R4
            m_sum = m_sum + rec - m_hist.pop_back();
            a = m_sum >>> 5;
            if (a > 511) a = 511;
            if (a < -512) a = -512;
            m_dac = a >>> 5;
            ab = (c < 0) ? -c : c;                             // R5
            wm = (ab > m_wmax) ? ab : m_wmax;
            m_chg = 0;
            if (m_cnt == 15) begin
                m_lpf = m_lpf + ((wm - m_lpf) >>> 3);          // R6
                if (m_lpf < int'(thr_low)) begin              // R7
                    if (m_g < 5) begin m_g++; m_chg = 1; end   // R8
                end else if (m_lpf > int'(thr_high)) begin
                    if (m_g > -2) begin m_g--; m_chg = 1; end
                end
                m_cnt = 0; m_wmax = 0;
            end else begin
                m_cnt++; m_wmax = wm;
            end
        end else begin
            m_rvalid = 0;                                      // R10
            m_chg = 0;
        end
    end

    // Per-cycle comparison away from the active edge; also the watchdog
    always @(negedge clk) begin
        cycles++;
        if (!done && rst_n) begin
            check(recon_valid == m_rvalid, "R3 recon_valid", int'(recon_valid), int'(m_rvalid));
            check(int'(recon_sample) == m_rsamp, "R2/R3/R10 recon_sample", int'(recon_sample), m_rsamp);
            check(int'($signed(dac_code)) == m_dac, "R4 dac_code", int'($signed(dac_code)), m_dac);
            // gain path covers R5 peak window, R6 filter, R7 decision
            check(int'(gain_exp) == m_g, "R5/R6/R7 gain_exp", int'(gain_exp), m_g);
            check(gain_changed == m_chg, "R9 gain_changed", int'(gain_changed), int'(m_chg));
        end
        if (cycles > 150000 && !done) begin
            check(1'b0, "watchdog", cycles, 150000);
            report();
        end
    end

    function automatic int tri_wave(input int k, input int amp, input int period);
        int p, half;
        p = k % period;
        half = period / 2;
        if (p < half) return -amp + (2 * amp * p) / half;
        return amp - (2 * amp * (p - half)) / half;
    endfunction

    // Drive n cycles; closed loop scales the input by the current gain
    task automatic drive(input int n, input int amp, input int period,
                         input int every, input bit closed);
        for (int k = 0; k < n; k++) begin
            int s, code;
            @(negedge clk);
            s = tri_wave(k, amp, period);
            if (closed) s = (gain_exp >= 0) ? (s <<< gain_exp) : (s >>> (-gain_exp));
            code = 512 + s;
            if (code < 0) code = 0;
            if (code > 1023) code = 1023;
            sample_code  = 10'(code);
            sample_valid = ((k % every) == 0);
        end
        @(negedge clk);
        sample_valid = 1'b0;
    endtask

    task automatic report();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    endtask

    initial begin
        model_reset();
        rst_n = 1'b0;
        sample_valid = 1'b1;
        sample_code = 10'd900;
        repeat (3) @(negedge clk);
        // R1: reset state visible at the ports
        check(gain_exp == 0, "R1 gain_exp", int'(gain_exp), 0);
        check(gain_changed == 0, "R1 gain_changed", int'(gain_changed), 0);
        check(dac_code == 0, "R1 dac_code", int'(dac_code), 0);
        check(recon_valid == 0, "R1 recon_valid", int'(recon_valid), 0);
        check(recon_sample == 0, "R1 recon_sample", int'(recon_sample), 0);
        sample_valid = 1'b0;
        rst_n = 1'b1;

        // Closed loop, small input: gain climbs until the peak enters the band
        drive(3000, 20, 40, 1, 1'b1);
        // Closed loop, larger input with gaps every third cycle (R10)
        drive(3000, 120, 36, 3, 1'b1);
        // Open loop near full scale: gain falls to its floor (R8)
        drive(2500, 500, 32, 1, 1'b0);
        check(gain_exp == -2, "R8 floor", int'(gain_exp), -2);
        // Open loop tiny input: gain rises to its ceiling (R8)
        drive(4000, 5, 20, 1, 1'b0);
        check(gain_exp == 5, "R8 ceiling", int'(gain_exp), 5);
        // Idle cycles: nothing moves (R10)
        begin
            int g0, d0, r0;
            g0 = int'(gain_exp); d0 = int'(dac_code); r0 = int'(recon_sample);
            repeat (50) @(negedge clk);
            check(int'(gain_exp) == g0, "R10 idle gain", int'(gain_exp), g0);
            check(int'(dac_code) == d0, "R10 idle dac", int'(dac_code), d0);
            check(int'(recon_sample) == r0, "R10 idle recon", int'(recon_sample), r0);
        end
        // Wide dead zone: mid amplitude holds the gain (R7)
        thr_low = 10'd0;
        thr_high = 10'd1023;
        begin
            int g1;
            g1 = int'(gain_exp);
            drive(1000, 200, 24, 1, 1'b0);
            check(int'(gain_exp) == g1, "R7 dead zone hold", int'(gain_exp), g1);
        end
        // Inverted thresholds: raise takes priority (R7)
        thr_low = 10'd600;
        thr_high = 10'd10;
        drive(600, 300, 30, 1, 1'b0);
        // Positive-offset input steers the running mean (R4)
        thr_low = 10'd100;
        thr_high = 10'd400;
        drive(800, 0, 8, 1, 1'b0);
        for (int k = 0; k < 200; k++) begin
            @(negedge clk);
            sample_code = 10'd1000;
            sample_valid = 1'b1;
        end
        @(negedge clk);
        sample_valid = 1'b0;
        repeat (4) @(negedge clk);
        report();
    end

endmodule